// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address that a synchronous memory core uses during a short burst. A controller presents one external address, and the sequencer then supplies up to four addresses that stay inside the aligned group of four words containing that start address. One control input chooses between taking a fresh address and stepping the burst. Another input chooses how the two low address bits move: a linear count, or an interleaved pattern formed by XOR with the beat number.

A global active-low clock enable suspends the sequencer. While it is inactive, every synchronous input is ignored and all state holds, including the hidden beat counter. The output is registered, so a change requested in one enabled cycle appears on `cur_addr` after the next rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: Reset clears `cur_addr` to zero and sets the beat count to zero. Reset takes effect without a clock edge. After release, an advance with no prior load with `order_sel`=0 yields address 1.
- R2: In an enabled cycle (`cke_n`=0) with `ld_n`=0, `cur_addr` equals `ext_addr` after the next rising edge, and the beat count restarts at zero.
- R3: Linear order (`order_sel`=0): after the k-th advance since a load, bits [1:0] of `cur_addr` equal (start low bits + k) mod 4.
- R4: Interleaved order (`order_sel`=1): after the k-th advance, bits [1:0] equal the start low bits XOR (k mod 4). A start of 1 gives 1,0,3,2.
- R5: The fourth advance after a load returns to the start address. The beat count wraps modulo 4 and never carries into the upper bits.
- R6: While `cke_n`=1, `cur_addr` holds its value whatever `ld_n`, `order_sel` and `ext_addr` do.
- R7: A suspension does not disturb the beat count. When the sequencer resumes, the burst continues from the beat where it stopped.
- R8: A load in the middle of a burst abandons that burst and restarts from beat zero at the new address.
- R9: During an advance, `ext_addr` is ignored and the upper bits of `cur_addr` (above bit 1) stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cke_n | input | 1 | Active-low clock enable; high suspends the sequencer |
| ld_n | input | 1 | Low loads `ext_addr`; high advances the burst |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| ext_addr | input | AW (18) | Externally presented start address |
| cur_addr | output | AW (18) | Current internal word address |

## Verification
The checker assumes that `cke_n` is held high for the two cycles in which the internal reset release moves through its synchronizer. This is needed because the load and beat properties use the raw reset for their disable condition. The bench meets this assumption by keeping the sequencer suspended for four cycles after every reset release. The beat-count properties assume nothing about `order_sel`. Apart from the reset window, the stimulus is therefore free to mix orders, loads, advances and suspensions in any sequence.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADV  = 2'd2
  } bseq_op_e;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } bseq_ord_e;

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic     cke_n,
  input  logic     ld_n,
  output bseq_op_e op
);

  always_comb begin
    if (cke_n) begin
      op = OP_HOLD;
    end else if (!ld_n) begin
      op = OP_LOAD;
    end else begin
      op = OP_ADV;
    end
  end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import bseq_pkg::*;
#(
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bseq_op_e      op,
  output logic [GW-1:0] beat_q,
  output logic [GW-1:0] beat_nxt
);

  logic [GW-1:0] beat_d;

  // Plain modulo-2^GW count: the carry out is dropped, so the burst wraps.
  assign beat_nxt = beat_q + GW'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: beat_d = '0;
      OP_ADV:  beat_d = beat_nxt;
      default: beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int GW = 2
) (
  input  logic [GW-1:0] start_lo,
  input  logic [GW-1:0] beat,
  input  bseq_ord_e     ord,
  output logic [GW-1:0] mapped_lo
);

  logic [GW-1:0] lin_lo;
  logic [GW-1:0] xor_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < GW; b++) begin : g_xor_bit
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  always_comb begin
    unique case (ord)
      ORD_XOR: mapped_lo = xor_lo;
      default: mapped_lo = lin_lo;
    endcase
  end

endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
  import bseq_pkg::*;
#(
  parameter int AW = 18,
  parameter int GW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bseq_op_e      op,
  input  logic [AW-1:0] ext_addr,
  input  logic [GW-1:0] mapped_lo,
  output logic [GW-1:0] start_q,
  output logic [AW-1:0] cur_q
);

  logic [AW-1:0] cur_d;
  logic [GW-1:0] start_d;

  always_comb begin
    cur_d   = cur_q;
    start_d = start_q;
    unique case (op)
      OP_LOAD: begin
        cur_d   = ext_addr;
        start_d = ext_addr[GW-1:0];
      end
      OP_ADV: begin
        cur_d = {cur_q[AW-1:GW], mapped_lo};
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      start_q <= '0;
    end else begin
      cur_q   <= cur_d;
      start_q <= start_d;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW          = 18,
  parameter int GW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          ld_n,
  input  logic          order_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr
);

  logic          rst_int_n;
  bseq_op_e      op;
  bseq_ord_e     ord;
  logic [GW-1:0] beat_q;
  logic [GW-1:0] beat_nxt;
  logic [GW-1:0] start_q;
  logic [GW-1:0] mapped_lo;

  assign ord = bseq_ord_e'(order_sel);

  bseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bseq_decode u_decode (
    .cke_n (cke_n),
    .ld_n  (ld_n),
    .op    (op)
  );

  bseq_beat_ctr #(.GW(GW)) u_beat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op       (op),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  bseq_order_map #(.GW(GW)) u_map (
    .start_lo  (start_q),
    .beat      (beat_nxt),
    .ord       (ord),
    .mapped_lo (mapped_lo)
  );

  bseq_addr_reg #(.AW(AW), .GW(GW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .op        (op),
    .ext_addr  (ext_addr),
    .mapped_lo (mapped_lo),
    .start_q   (start_q),
    .cur_q     (cur_addr)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int AW = 18,
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          ld_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr,
  input logic [GW-1:0] beat
);

  // R6
  hold_when_suspended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(cur_addr));

  // R2
  load_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n) |=> (cur_addr == $past(ext_addr)));

  // R9
  upper_kept_on_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && ld_n) |=> (cur_addr[AW-1:GW] == $past(cur_addr[AW-1:GW])));

  // R8
  load_zeroes_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n) |=> (beat == '0));

  // R5
  beat_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && ld_n) |=> (beat == GW'($past(beat) + 1'b1)));

  // R7
  beat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(beat));

endmodule

bind burst_addr_seq bseq_chk #(.AW(AW), .GW(GW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke_n    (cke_n),
  .ld_n     (ld_n),
  .ext_addr (ext_addr),
  .cur_addr (cur_addr),
  .beat     (beat_q)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 18;
  localparam int NV = 18;
  localparam int VW = 3 + 2 * AW;

  logic          clk;
  logic          rst_n;
  logic          cke_n;
  logic          ld_n;
  logic          order_sel;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] cur_addr;

  int n_checks;
  int n_errors;
  bit done;

  burst_addr_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .ld_n      (ld_n),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .cur_addr  (cur_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: {cke_n, ld_n, order_sel, ext_addr, expected cur_addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b000, 18'h12345, 18'h12345},  // R2 load, start low bits 01
    {3'b010, 18'h00000, 18'h12346},  // R3 linear step 1
    {3'b010, 18'h3FFFF, 18'h12347},  // R9 ext ignored on advance
    {3'b010, 18'h00000, 18'h12344},  // R3 wrap within group
    {3'b010, 18'h00000, 18'h12345},  // R5 back to start
    {3'b100, 18'h00AAA, 18'h12345},  // R6 suspend with load request
    {3'b001, 18'h2ABC9, 18'h2ABC9},  // R2 load, interleaved
    {3'b011, 18'h00000, 18'h2ABC8},  // R4 1 -> 0
    {3'b011, 18'h00000, 18'h2ABCB},  // R4 -> 3
    {3'b011, 18'h00000, 18'h2ABCA},  // R4 -> 2
    {3'b011, 18'h00000, 18'h2ABC9},  // R5 wrap
    {3'b001, 18'h0000E, 18'h0000E},  // R2 load, start 2
    {3'b011, 18'h00000, 18'h0000F},  // R4 beat 1
    {3'b111, 18'h3FFFF, 18'h0000F},  // R6 suspend
    {3'b101, 18'h12345, 18'h0000F},  // R6 suspend
    {3'b011, 18'h00000, 18'h0000C},  // R7 resumes at beat 2
    {3'b000, 18'h1FFF3, 18'h1FFF3},  // R8 load mid-burst
    {3'b010, 18'h00000, 18'h1FFF0}   // R8 restarted at beat 1, no carry
  };

  function automatic string vec_req(int i);
    case (i)
      0, 6, 11: return "R2";
      1, 3:     return "R3";
      2:        return "R9";
      4, 10:    return "R5";
      5, 13, 14: return "R6";
      7, 8, 9, 12: return "R4";
      15:       return "R7";
      default:  return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: cur_addr=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic c, logic l, logic o, logic [AW-1:0] a);
    cke_n     = c;
    ld_n      = l;
    order_sel = o;
    ext_addr  = a;
    @(negedge clk);
  endtask

  task automatic release_reset();
    cke_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: cur_addr=%h expected=completion", cur_addr);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    cke_n     = 1'b1;
    ld_n      = 1'b1;
    order_sel = 1'b0;
    ext_addr  = '0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R1", cur_addr, '0);
    release_reset();
    check("R1", cur_addr, '0);

    // R1: advance with no load starts from a cleared beat count
    drive(1'b0, 1'b1, 1'b0, 18'h3FFFF);
    check("R1", cur_addr, 18'h00001);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][VW-1], VEC[i][VW-2], VEC[i][VW-3], VEC[i][2*AW-1:AW]);
      check(vec_req(i), cur_addr, VEC[i][AW-1:0]);
    end

    // R3 R4 R5: every start and both orders, five advances each
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = {16'hBEEF, 2'(s)};
        drive(1'b0, 1'b0, 1'(ord), base);
        check("R2", cur_addr, base);
        for (int k = 1; k <= 5; k++) begin
          logic [1:0] lo;
          lo = (ord == 1) ? (2'(s) ^ 2'(k)) : 2'(s + k);
          drive(1'b0, 1'b1, 1'(ord), 18'h3FFFF);
          check((ord == 1) ? "R4" : ((k % 4 == 0) ? "R5" : "R3"),
                cur_addr, {16'hBEEF, lo});
        end
      end
    end

    // R1: asynchronous reset mid-burst clears without a clock edge
    drive(1'b0, 1'b0, 1'b0, 18'h2A5A7);
    check("R2", cur_addr, 18'h2A5A7);
    #1 rst_n = 1'b0;
    #1 check("R1", cur_addr, '0);
    release_reset();
    check("R1", cur_addr, '0);
    drive(1'b0, 1'b1, 1'b1, 18'h11111);
    check("R1", cur_addr, 18'h00001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule